// File: doc/BRIEF.md
# Receive FIFO Interrupt Generator

This block watches the occupancy of a serial receiver's FIFO and turns it into the receive-side interrupt conditions. It raises a data-available interrupt when the FIFO fill reaches a chosen trigger level. It raises a character-timeout interrupt when characters sit in the FIFO and both the line and the host have been idle long enough. It keeps a data-ready flag, and it folds these interrupts and a line-status error into one prioritised identification code and a single interrupt request line.

The FIFO storage, the serial receiver and the baud logic sit outside the block. The FIFO supplies its fill count. The receiver pulses a strobe for each character it stores. The host interface pulses a strobe for each character it reads. The baud logic pulses a tick once per character time, and the second stop bit is included in that time when two stop bits are configured. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `rx_fifo_irq`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are cleared after that edge and `iid` reads 4'b0001.
- R2: `data_ready` is 1 after any edge that samples `rx_push` high. Otherwise it goes to 0 after an edge that samples `fifo_count` equal to 0, and it holds in all other cases.
- R3: `rda_irq` is 1 after an edge exactly when the enables are set and `fifo_count` is at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 characters.
- R4: With `fifo_en` or `rx_ie` low, no receive interrupt is raised. The line-status interrupt additionally requires `ls_ie` high.
- R5: The idle timer counts `char_tick` pulses and saturates at 5. Any `rx_push` or `host_read` restarts it from 0, whether or not a timeout is pending.
- R6: `tmo_irq` is 1 after an edge when the enables are set, `fifo_count` is non-zero, the timer already holds 5 ticks and neither strobe is high.
- R7: A single `host_read` clears `tmo_irq` after the next edge.
- R8: `iid` is {code, 0} while an interrupt is pending. The codes are 3'b011 for a line-status error, 3'b010 for data available and 3'b110 for timeout. Line status outranks the other two. Data available and timeout share one level, and data available is reported when both are pending. With nothing pending `iid` is 4'b0001.
- R9: `irq` is high exactly when `iid[0]` is 0, and both update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_ie | input | 1 | Receive data interrupt enable |
| ls_ie | input | 1 | Line-status interrupt enable |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| fifo_count | input | CW | Current FIFO occupancy |
| rx_push | input | 1 | Character written into FIFO this cycle |
| host_read | input | 1 | Host read one character this cycle |
| ls_err | input | 1 | Line-status error present |
| char_tick | input | 1 | One pulse per character time |
| data_ready | output | 1 | At least one character held |
| rda_irq | output | 1 | Trigger level reached |
| tmo_irq | output | 1 | Character timeout |
| iid | output | 4 | Interrupt identification {code, none-pending} |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the exact tick on which the timeout fires. A design that fires after four ticks, or fails to restart the timer on a host read, shows `tmo_irq` a cycle or several cycles off. It also checks that the level comparison is inclusive, with each trigger code exercised at and just below its threshold. A strict comparison or a wrong level table leaves `rda_irq` late or early. Simultaneous line-status, data-available and timeout conditions check that a wrong priority shows up as a wrong `iid`. The bench also covers a push arriving in the same cycle as an empty count, where a data-ready flag that lets the clear win would drop its flag.

// File: rtl/rx_fifo_irq_pkg.sv
package rx_fifo_irq_pkg;

  typedef struct packed {
    logic ls;
    logic rda;
    logic tmo;
  } pend_t;

  localparam logic [2:0] ID_LS  = 3'b011;
  localparam logic [2:0] ID_RDA = 3'b010;
  localparam logic [2:0] ID_TMO = 3'b110;
  localparam logic [3:0] IID_IDLE = 4'b0001;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_irq_level.sv
module rx_fifo_irq_level #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] count,
  input  logic [1:0]    sel,
  output logic          reached
);
  import rx_fifo_irq_pkg::*;

  logic [CW-1:0] level;

  always_comb begin
    level   = CW'(trig_level(sel));
    reached = (count >= level);
  end
endmodule

// File: rtl/rx_fifo_irq_timer.sv
module rx_fifo_irq_timer #(
  parameter int TMO_CHARS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int SAT = TMO_CHARS + 1;
  localparam int AW  = $clog2(SAT + 1);
  localparam logic [AW-1:0] SAT_V = AW'(SAT);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (restart) begin
      age_q <= '0;
    end else if (tick && (age_q != SAT_V)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign expired = (age_q == SAT_V);
endmodule

// File: rtl/rx_fifo_irq_prio.sv
module rx_fifo_irq_prio
  import rx_fifo_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pend_t      pend,
  output logic [3:0] iid,
  output logic       irq
);
  logic [3:0] iid_n;

  always_comb begin
    if (pend.ls)       iid_n = {ID_LS, 1'b0};
    else if (pend.rda) iid_n = {ID_RDA, 1'b0};
    else if (pend.tmo) iid_n = {ID_TMO, 1'b0};
    else               iid_n = IID_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iid <= IID_IDLE;
      irq <= 1'b0;
    end else begin
      iid <= iid_n;
      irq <= pend.ls | pend.rda | pend.tmo;
    end
  end
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          rx_ie,
  input  logic          ls_ie,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] fifo_count,
  input  logic          rx_push,
  input  logic          host_read,
  input  logic          ls_err,
  input  logic          char_tick,
  output logic          data_ready,
  output logic          rda_irq,
  output logic          tmo_irq,
  output logic [3:0]    iid,
  output logic          irq
);
  import rx_fifo_irq_pkg::*;

  logic  rx_en;
  logic  level_hit;
  logic  idle_expired;
  logic  fifo_nonempty;
  pend_t pend_n;

  assign rx_en         = fifo_en & rx_ie;
  assign fifo_nonempty = (fifo_count != '0);

  rx_fifo_irq_level #(.CW(CW)) u_level (
    .count   (fifo_count),
    .sel     (trig_sel),
    .reached (level_hit)
  );

  rx_fifo_irq_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (rx_push | host_read),
    .tick    (char_tick),
    .expired (idle_expired)
  );

  always_comb begin
    pend_n.ls  = rx_en & ls_ie & ls_err;
    pend_n.rda = rx_en & level_hit;
    pend_n.tmo = rx_en & fifo_nonempty & idle_expired & ~rx_push & ~host_read;
  end

  rx_fifo_irq_prio u_prio (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_n),
    .iid  (iid),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      rda_irq    <= 1'b0;
      tmo_irq    <= 1'b0;
    end else begin
      if (rx_push)             data_ready <= 1'b1;
      else if (!fifo_nonempty) data_ready <= 1'b0;
      rda_irq <= pend_n.rda;
      tmo_irq <= pend_n.tmo;
    end
  end
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rx_ie,
  input logic          ls_ie,
  input logic [1:0]    trig_sel,
  input logic [CW-1:0] fifo_count,
  input logic          rx_push,
  input logic          host_read,
  input logic          ls_err,
  input logic          data_ready,
  input logic          rda_irq,
  input logic          tmo_irq,
  input logic [3:0]    iid,
  input logic          irq
);
  import rx_fifo_irq_pkg::*;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (iid == IID_IDLE) && !irq && !data_ready && !rda_irq && !tmo_irq);

  p_push_sets_ready_r2: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> data_ready);

  p_level_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && rx_ie && (int'(fifo_count) >= int'(trig_level(trig_sel)))) |=> rda_irq);

  p_gated_off_r4: assert property (@(posedge clk) disable iff (rst)
    !(fifo_en && rx_ie) |=> !rda_irq && !tmo_irq && iid[0]);

  p_tmo_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_irq) |-> $past(fifo_count) != '0);

  p_read_clears_tmo_r7: assert property (@(posedge clk) disable iff (rst)
    host_read |=> !tmo_irq);

  p_ls_first_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && rx_ie && ls_ie && ls_err) |=> (iid == {ID_LS, 1'b0}));

  p_irq_matches_iid_r9: assert property (@(posedge clk) disable iff (rst)
    irq == !iid[0]);
endmodule

bind rx_fifo_irq rx_fifo_irq_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_en    (fifo_en),
  .rx_ie      (rx_ie),
  .ls_ie      (ls_ie),
  .trig_sel   (trig_sel),
  .fifo_count (fifo_count),
  .rx_push    (rx_push),
  .host_read  (host_read),
  .ls_err     (ls_err),
  .data_ready (data_ready),
  .rda_irq    (rda_irq),
  .tmo_irq    (tmo_irq),
  .iid        (iid),
  .irq        (irq)
);

// File: tb/rx_fifo_irq_bench.sv
module rx_fifo_irq_bench;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0, rx_ie = 1'b0, ls_ie = 1'b0;
  logic [1:0]    trig_sel = 2'd0;
  logic [CW-1:0] fifo_count = '0;
  logic          rx_push = 1'b0, host_read = 1'b0, ls_err = 1'b0, char_tick = 1'b0;
  logic          data_ready, rda_irq, tmo_irq, irq;
  logic [3:0]    iid;

  int tests = 0, fails = 0;
  int occ = 0;
  bit started = 0;
  bit done = 0;

  bit e_dr, e_rda, e_tmo, e_irq;
  int e_iid;
  int age;

  always #5 clk = ~clk;

  rx_fifo_irq #(.DEPTH(DEPTH)) u_rx_fifo_irq (
    .clk, .rst, .fifo_en, .rx_ie, .ls_ie, .trig_sel, .fifo_count,
    .rx_push, .host_read, .ls_err, .char_tick,
    .data_ready, .rda_irq, .tmo_irq, .iid, .irq
  );

  // Behavioural reference, advanced at each rising edge.
  always @(posedge clk) begin
    bit en, n_ls, n_rda, n_tmo;
    int lvl;
    started = 1;
    if (rst) begin
      e_dr = 0; e_rda = 0; e_tmo = 0; e_irq = 0; e_iid = 1; age = 0;
    end else begin
      en  = fifo_en && rx_ie;
      lvl = (trig_sel == 0) ? 1 : (trig_sel == 1) ? 4 : (trig_sel == 2) ? 8 : 14;
      n_ls  = en && ls_ie && ls_err;
      n_rda = en && (int'(fifo_count) >= lvl);
      n_tmo = en && (fifo_count != 0) && (age >= 5) && !rx_push && !host_read;
      if (rx_push) e_dr = 1;
      else if (fifo_count == 0) e_dr = 0;
      if (rx_push || host_read) age = 0;
      else if (char_tick && age < 5) age = age + 1;
      e_rda = n_rda;
      e_tmo = n_tmo;
      e_irq = n_ls || n_rda || n_tmo;
      e_iid = n_ls ? 6 : n_rda ? 4 : n_tmo ? 12 : 1;
    end
    occ = occ + (rx_push ? 1 : 0) - (host_read ? 1 : 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (rst) begin
        chk("R1 iid idle in reset", int'(iid), 1);
        chk("R1 irq low in reset", int'(irq), 0);
      end else begin
        chk("R2 data_ready", int'(data_ready), int'(e_dr));
        chk("R3/R4 rda_irq", int'(rda_irq), int'(e_rda));
        chk("R5/R6/R7 tmo_irq", int'(tmo_irq), int'(e_tmo));
        chk("R8 iid", int'(iid), e_iid);
        chk("R9 irq", int'(irq), int'(e_irq));
      end
    end
  end

  task automatic cyc(input bit p, input bit r, input bit t, input bit e);
    @(negedge clk);
    #1;
    fifo_count = CW'(occ);
    rx_push    = p && (occ < DEPTH);
    host_read  = r && (occ > 0);
    char_tick  = t;
    ls_err     = e;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: hold reset for a few edges
    repeat (3) cyc(0, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0);
    fifo_en = 1; rx_ie = 1; ls_ie = 1;

    // R3: each trigger level, filling past it and draining below it
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      for (int i = 0; i < 15; i++) cyc(0, 1, 0, 0);
      repeat (2) cyc(0, 0, 0, 0);
    end

    // R2: push in same cycle as an empty count
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    repeat (2) cyc(0, 0, 0, 0);

    // R5/R6/R7: timeout after five idle ticks, then one read clears it
    trig_sel = 2'd3;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, i % 2 == 0, 0);
    // R5: reads every four ticks keep the timer from expiring
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, i % 5 == 4, 1, 0);
    // R6: drain to empty, ticks must not raise a timeout
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0);

    // R8: line status over data available over timeout
    trig_sel = 2'd0;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    trig_sel = 2'd2;
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 0);

    // R4: enables gate every receive interrupt
    ls_ie = 0;
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    ls_ie = 1; rx_ie = 0;
    cyc(0, 0, 0, 1); for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    rx_ie = 1; fifo_en = 0;
    cyc(0, 0, 0, 1); cyc(0, 0, 1, 0);
    fifo_en = 1;
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);

    // Mixed traffic over all controls
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        trig_sel = 2'($urandom_range(0, 3));
        ls_ie    = ($urandom_range(0, 3) != 0);
        rx_ie    = ($urandom_range(0, 5) != 0);
        fifo_en  = ($urandom_range(0, 5) != 0);
      end
      cyc($urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 30) == 0);
    end

    // R1: reset again mid-stream
    rst = 1'b1;
    repeat (2) cyc(0, 0, 0, 0);
    rst = 1'b0;
    repeat (3) cyc(0, 0, 0, 0);

    @(negedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule